// File: doc/BRIEF.md
# Sequential Integer Multiply Coprocessor

This unit sits on a CPU's coprocessor port and takes over the four 32-bit integer multiply operations. They are the low half of the product and three high-half forms: signed by signed, signed by unsigned, and unsigned by unsigned. The host presents a request strobe, the raw 32-bit instruction word and the two source operand values. The unit decodes the word itself. If the word is a multiply, it raises a busy indication on the following cycle, so the host's 16-cycle "nobody answered" trap never fires. It then computes the product one multiplier bit per cycle with a shift-and-add datapath.

When the product is ready, the unit pulses a completion strobe and a register-write strobe for one cycle, together with the result. The host then drops its request, and the unit returns to idle. If the host withdraws the request while the product is still being formed, the operation is abandoned and no result is returned.

Top module: `seqmul_cop`

## Requirements
- R1: A word is accepted only when bits [6:0] = 0110011, bits [31:25] = 0000001 and bits [14:12] are 000, 001, 010 or 011. Any other word presented with the request strobe never raises busy or completion.
- R2: Busy rises in the cycle after the first request cycle of an accepted word. It stays high without a gap until the cycle before completion, and it is never high together with completion.
- R3: For bits [14:12] = 000, completion is high exactly 40 cycles after the first request cycle.
- R4: For bits [14:12] = 001, 010 or 011, completion is high exactly 72 cycles after the first request cycle.
- R5: For 000, the result is the low 32 bits of the product of the two operands.
- R6: For 001, the result is the high 32 bits of the 64-bit product with both operands taken as signed.
- R7: For 010, the result is the high 32 bits with the first operand signed and the second unsigned.
- R8: For 011, the result is the high 32 bits with both operands unsigned.
- R9: Completion and the write strobe are the same single-cycle pulse. The result output is zero in every other cycle.
- R10: After completion, a request strobe that is still held high starts nothing. A new operation needs the strobe to be low for at least one cycle.
- R11: If the request strobe is low at any clock edge during busy, busy drops in the next cycle and no completion follows.
- R12: While reset is held and in the first cycle after it, busy, completion, the write strobe and the result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request strobe |
| req_insn | input | 32 | Raw instruction word |
| req_op_a | input | 32 | First source operand |
| req_op_b | input | 32 | Second source operand |
| rsp_wr | output | 1 | Register-write strobe for the result |
| rsp_data | output | 32 | Result value |
| rsp_wait | output | 1 | Busy: the word was accepted and is being computed |
| rsp_ready | output | 1 | Completion strobe |

## Verification
The completion strobe can land in the same cycle as the host withdrawing its request, and there are two variants of this.

In the first, the strobe drops at the edge that would have ended the last busy cycle. The bench checks that the operation is abandoned: no completion, and busy gone one cycle later.

In the second, the strobe drops during the completion cycle itself. The bench re-raises it one cycle later with a fresh word and checks that the new operation again takes its full latency.

A cycle-level model in the bench predicts every output on every clock, so both races are judged on every cycle, not only at the end.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;

    localparam int INSN_W = 32;
    localparam logic [6:0] OPC_REGREG  = 7'b0110011;
    localparam logic [6:0] F7_MULDIV   = 7'b0000001;

    typedef enum logic [1:0] {
        K_LO  = 2'd0,
        K_HSS = 2'd1,
        K_HSU = 2'd2,
        K_HUU = 2'd3
    } mul_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUSY,
        ST_DONE,
        ST_HOLD
    } seq_state_e;

    typedef struct packed {
        logic      hit;
        mul_kind_e kind;
    } dec_t;

    typedef struct packed {
        logic a_signed;
        logic b_signed;
        logic upper;
    } ext_cfg_t;

    function automatic dec_t decode_word(input logic [INSN_W-1:0] w);
        dec_t d;
        d.hit  = (w[6:0] == OPC_REGREG) && (w[31:25] == F7_MULDIV) && (w[14] == 1'b0);
        d.kind = mul_kind_e'(w[13:12]);
        return d;
    endfunction

    function automatic ext_cfg_t kind_cfg(input mul_kind_e k);
        ext_cfg_t c;
        c.a_signed = (k == K_HSS) || (k == K_HSU);
        c.b_signed = (k == K_HSS);
        c.upper    = (k != K_LO);
        return c;
    endfunction

endpackage

// File: rtl/seqmul_decode.sv
module seqmul_decode
    import seqmul_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);
    always_comb begin
        dec = decode_word(insn);
    end
endmodule

// File: rtl/seqmul_ctrl.sv
module seqmul_ctrl
    import seqmul_pkg::*;
#(
    parameter int LAT_LO   = 40,
    parameter int LAT_HI   = 72,
    parameter int STEPS_LO = 32,
    parameter int STEPS_HI = 64,
    localparam int CW      = $clog2(LAT_HI + 1)
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       valid,
    input  logic       hit,
    input  mul_kind_e  kind,
    output logic       start,
    output logic       step,
    output seq_state_e state
);
    seq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    mul_kind_e     kind_q;
    logic [CW-1:0] last_cnt;
    logic [CW-1:0] step_lim;

    always_comb begin
        last_cnt = (kind_q == K_LO) ? CW'(LAT_LO - 1) : CW'(LAT_HI - 1);
        step_lim = (kind_q == K_LO) ? CW'(STEPS_LO)   : CW'(STEPS_HI);
        start    = (state_q == ST_IDLE) && valid && hit;
        step     = (state_q == ST_BUSY) && valid && (cnt_q <= step_lim);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_BUSY;
            ST_BUSY: begin
                if (!valid)                 state_d = ST_IDLE;
                else if (cnt_q == last_cnt) state_d = ST_DONE;
            end
            ST_DONE: state_d = valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: if (!valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            kind_q  <= K_LO;
        end else begin
            state_q <= state_d;
            if (start) begin
                cnt_q  <= CW'(1);
                kind_q <= kind;
            end else if (state_q == ST_BUSY && valid) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign state = state_q;
endmodule

// File: rtl/seqmul_dpath.sv
module seqmul_dpath
    import seqmul_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int PW  = 2 * XLEN
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            step,
    input  mul_kind_e       kind,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output logic [XLEN-1:0] result
);
    logic [PW-1:0] mcand_q, mplier_q, acc_q;
    logic          upper_q;
    ext_cfg_t      cfg;
    logic [PW-1:0] a_ext, b_ext, addend;

    always_comb begin
        cfg    = kind_cfg(kind);
        a_ext  = {{XLEN{cfg.a_signed & op_a[XLEN-1]}}, op_a};
        b_ext  = {{XLEN{cfg.b_signed & op_b[XLEN-1]}}, op_b};
        addend = mplier_q[0] ? mcand_q : '0;
        result = upper_q ? acc_q[PW-1:XLEN] : acc_q[XLEN-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            acc_q    <= '0;
            upper_q  <= 1'b0;
        end else if (start) begin
            mcand_q  <= a_ext;
            mplier_q <= b_ext;
            acc_q    <= '0;
            upper_q  <= cfg.upper;
        end else if (step) begin
            acc_q    <= acc_q + addend;
            mcand_q  <= {mcand_q[PW-2:0], 1'b0};
            mplier_q <= {1'b0, mplier_q[PW-1:1]};
        end
    end
endmodule

// File: rtl/seqmul_cop.sv
module seqmul_cop
    import seqmul_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int LAT_LO = 40,
    parameter int LAT_HI = 72
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [31:0]     req_insn,
    input  logic [XLEN-1:0] req_op_a,
    input  logic [XLEN-1:0] req_op_b,
    output logic            rsp_wr,
    output logic [XLEN-1:0] rsp_data,
    output logic            rsp_wait,
    output logic            rsp_ready
);
    localparam int STEPS_LO = XLEN;
    localparam int STEPS_HI = 2 * XLEN;

    dec_t            dec;
    logic            start, step;
    seq_state_e      state;
    logic [XLEN-1:0] result;

    seqmul_decode u_dec (
        .insn (req_insn),
        .dec  (dec)
    );

    seqmul_ctrl #(
        .LAT_LO   (LAT_LO),
        .LAT_HI   (LAT_HI),
        .STEPS_LO (STEPS_LO),
        .STEPS_HI (STEPS_HI)
    ) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .valid (req_valid),
        .hit   (dec.hit),
        .kind  (dec.kind),
        .start (start),
        .step  (step),
        .state (state)
    );

    seqmul_dpath #(.XLEN(XLEN)) u_dp (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .step   (step),
        .kind   (dec.kind),
        .op_a   (req_op_a),
        .op_b   (req_op_b),
        .result (result)
    );

    always_comb begin
        rsp_wait  = (state == ST_BUSY);
        rsp_ready = (state == ST_DONE);
        rsp_wr    = rsp_ready;
        rsp_data  = rsp_ready ? result : '0;
    end
endmodule

// File: rtl/seqmul_cop_chk.sv
module seqmul_cop_chk #(
    parameter int XLEN   = 32,
    parameter int LAT_HI = 72
)(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            rsp_wr,
    input logic [XLEN-1:0] rsp_data,
    input logic            rsp_wait,
    input logic            rsp_ready
);
    int unsigned wait_run;

    always_ff @(posedge clk) begin
        if (rst)           wait_run <= 0;
        else if (rsp_wait) wait_run <= wait_run + 1;
        else               wait_run <= 0;
    end

    assert_wait_ready_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(rsp_wait && rsp_ready));

    assert_wait_continues_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_wait && req_valid) |=> (rsp_wait || rsp_ready));

    assert_wait_window_R4: assert property (@(posedge clk) disable iff (rst)
        wait_run < LAT_HI);

    assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_ready |=> !rsp_ready);

    assert_wr_with_ready_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_wr == rsp_ready);

    assert_data_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !rsp_ready |-> (rsp_data == '0));

    assert_no_restart_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_ready |=> !rsp_wait);

    assert_abort_R11: assert property (@(posedge clk) disable iff (rst)
        (rsp_wait && !req_valid) |=> (!rsp_wait && !rsp_ready));
endmodule

bind seqmul_cop seqmul_cop_chk #(.XLEN(XLEN), .LAT_HI(LAT_HI)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .rsp_wr    (rsp_wr),
    .rsp_data  (rsp_data),
    .rsp_wait  (rsp_wait),
    .rsp_ready (rsp_ready)
);

// File: tb/sim_seqmul_cop.sv
module sim_seqmul_cop;
    localparam int CLK_PERIOD = 10;
    localparam int LO_LAT = 40;
    localparam int HI_LAT = 72;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_insn = '0, req_a = '0, req_b = '0;
    logic        rsp_wr, rsp_wait, rsp_ready;
    logic [31:0] rsp_data;

    int checks = 0;
    int errors = 0;

    // behavioural reference: 0 idle, 1 computing, 2 result cycle, 3 waiting for drop
    int          m_state = 0;
    int          m_cyc = 0;
    int          m_lat = 0;
    logic [31:0] m_res = '0;
    string       m_tag = "R5";

    seqmul_cop u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_insn(req_insn),
        .req_op_a(req_a), .req_op_b(req_b), .rsp_wr(rsp_wr), .rsp_data(rsp_data),
        .rsp_wait(rsp_wait), .rsp_ready(rsp_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit claims(input logic [31:0] w);
        return (w[6:0] == 7'b0110011) && (w[31:25] == 7'b0000001) && (w[14:12] <= 3'd3);
    endfunction

    function automatic logic [31:0] ref_product(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] x, y, p;
        x = (f3 == 3'd1 || f3 == 3'd2) ? {{32{a[31]}}, a} : {32'b0, a};
        y = (f3 == 3'd1) ? {{32{b[31]}}, b} : {32'b0, b};
        p = x * y;
        return (f3 == 3'd0) ? p[31:0] : p[63:32];
    endfunction

    function automatic string tag_of(input logic [2:0] f3);
        case (f3)
            3'd0: return "R5";
            3'd1: return "R6";
            3'd2: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [31:0] mk(input logic [2:0] f3);
        return {7'b0000001, 5'd2, 5'd1, f3, 5'd3, 7'b0110011};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0;
        end else begin
            case (m_state)
                0: if (req_valid && claims(req_insn)) begin
                       m_state = 1; m_cyc = 1;
                       m_lat = (req_insn[14:12] == 3'd0) ? LO_LAT : HI_LAT;
                       m_res = ref_product(req_insn[14:12], req_a, req_b);
                       m_tag = tag_of(req_insn[14:12]);
                   end
                1: if (!req_valid) m_state = 0;
                   else if (m_cyc == m_lat - 1) m_state = 2;
                   else m_cyc++;
                2: m_state = req_valid ? 3 : 0;
                default: if (!req_valid) m_state = 0;
            endcase
        end
    end

    // per-cycle comparison against the model (R2, R3, R4, R9 and the result tags)
    always @(negedge clk) begin
        if (!rst) begin
            check(rsp_wait == (m_state == 1), "R2", {31'b0, rsp_wait}, {31'b0, m_state == 1});
            check(rsp_ready == (m_state == 2), (m_lat == LO_LAT) ? "R3" : "R4",
                  {31'b0, rsp_ready}, {31'b0, m_state == 2});
            check(rsp_wr == (m_state == 2), "R9", {31'b0, rsp_wr}, {31'b0, m_state == 2});
            if (m_state == 2) check(rsp_data == m_res, m_tag, rsp_data, m_res);
            else              check(rsp_data == 32'b0, "R9", rsp_data, 32'b0);
        end
    end

    task automatic run_op(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b, input int hold);
        int k = 0;
        int lat = (f3 == 3'd0) ? LO_LAT : HI_LAT;
        req_insn = mk(f3); req_a = a; req_b = b; req_valid = 1'b1;
        while (k < 200) begin
            @(negedge clk); k++;
            if (rsp_ready) break;
        end
        check(k == lat, (f3 == 3'd0) ? "R3" : "R4", k, lat);
        check(rsp_data == ref_product(f3, a, b), tag_of(f3), rsp_data, ref_product(f3, a, b));
        check(rsp_wr == 1'b1, "R9", {31'b0, rsp_wr}, 32'd1);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check(!rsp_wait && !rsp_ready, "R10", {30'b0, rsp_wait, rsp_ready}, 32'd0);
        end
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!rsp_wait && !rsp_ready && !rsp_wr && rsp_data == 0, "R12",
              {rsp_data[28:0], rsp_wait, rsp_ready, rsp_wr}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!rsp_wait && !rsp_ready && !rsp_wr && rsp_data == 0, "R12",
              {rsp_data[28:0], rsp_wait, rsp_ready, rsp_wr}, 32'd0);

        // main function, several operand patterns per form
        run_op(3'd0, 32'd7, 32'd9, 0);
        run_op(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2);
        run_op(3'd0, 32'h8000_0000, 32'd3, 0);
        run_op(3'd1, 32'h8000_0000, 32'h8000_0000, 0);
        run_op(3'd1, 32'hFFFF_FFFF, 32'd5, 3);
        run_op(3'd1, 32'h1234_5678, 32'h9ABC_DEF0, 0);
        run_op(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        run_op(3'd2, 32'h8000_0000, 32'h8000_0000, 1);
        run_op(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        run_op(3'd3, 32'hDEAD_BEEF, 32'h0000_0000, 0);
        run_op(3'd3, 32'h8765_4321, 32'hF0F0_F0F0, 4);

        // R1: words that must be left alone
        begin
            logic [31:0] others [3];
            others[0] = {7'b0000001, 5'd2, 5'd1, 3'b100, 5'd3, 7'b0110011};
            others[1] = {7'b0000000, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011};
            others[2] = {7'b0000001, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110111};
            for (int i = 0; i < 3; i++) begin
                int seen = 0;
                req_insn = others[i]; req_a = 32'd3; req_b = 32'd4; req_valid = 1'b1;
                for (int c = 0; c < 80; c++) begin
                    @(negedge clk);
                    if (rsp_wait || rsp_ready) seen++;
                end
                check(seen == 0, "R1", seen, 0);
                req_valid = 1'b0;
                @(negedge clk);
            end
        end

        // R11: withdraw mid-computation
        begin
            int seen = 0;
            req_insn = mk(3'd1); req_a = 32'd11; req_b = 32'd13; req_valid = 1'b1;
            repeat (10) @(negedge clk);
            req_valid = 1'b0;
            @(negedge clk);
            check(!rsp_wait, "R11", {31'b0, rsp_wait}, 32'd0);
            for (int c = 0; c < 80; c++) begin
                @(negedge clk);
                if (rsp_ready) seen++;
            end
            check(seen == 0, "R11", seen, 0);
        end

        // R11: withdraw at the edge that closes the last busy cycle
        begin
            int seen = 0;
            req_insn = mk(3'd0); req_a = 32'd5; req_b = 32'd6; req_valid = 1'b1;
            repeat (LO_LAT - 1) @(negedge clk);
            check(rsp_wait, "R2", {31'b0, rsp_wait}, 32'd1);
            req_valid = 1'b0;
            for (int c = 0; c < 10; c++) begin
                @(negedge clk);
                if (rsp_ready || rsp_wait) seen++;
            end
            check(seen == 0, "R11", seen, 0);
        end

        // R10: strobe dropped in the result cycle, then a fresh word right away
        run_op(3'd0, 32'd100, 32'd200, 0);
        run_op(3'd2, 32'hFFFF_FFFE, 32'd3, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule